// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path

This block is the read side of a synchronous SRAM core. It covers a small behavioural storage array, the command register, an optional output data register and the logic that drives the data bus. The chip enable, the write indication, the address and the write data are all sampled on the rising clock edge. A read makes the addressed word appear on the output. A write stores a word and never drives the bus.

A static strap picks the output timing. With the strap low, the block runs in flow-through mode: the word read from the array goes straight to the pins after the edge that samples the read. With the strap high, the block runs in pipelined mode: an extra rising-edge register adds one cycle of latency. A new address can be accepted on every cycle in either mode. A deselect travels down the same pipeline as a read, so in pipelined mode the bus is released one cycle late. The tri-state bus is modelled as a data word plus a drive-enable. The active-low output enable and the sleep input act at once, without waiting for a clock. While sleep is high, commands are ignored and the stored words are kept.

Top module: `srp_read_path`

## Requirements
- R1: After reset, with no command issued, `rdata_oe` is 0 and `rdata` is 0.
- R2: With `pipe_mode`=0, a read (ce=1, we=0) sampled at an edge drives the addressed word with `rdata_oe`=1 right after that same edge.
- R3: With `pipe_mode`=1, a read sampled at an edge leaves the bus undriven after that edge. It drives the addressed word right after the next edge.
- R4: Reads on consecutive cycles give one word per cycle in address order. A four-read burst finishes in 2-1-1-1 cycles in flow-through mode and 3-1-1-1 cycles in pipelined mode.
- R5: With `pipe_mode`=1, after a deselect (ce=0) sampled at an edge, the bus stays driven until the next edge. It is released right after that second edge.
- R6: With `pipe_mode`=0, a deselect releases the bus right after the edge that samples it.
- R7: A write (ce=1, we=1) never causes the bus to be driven. A pipelined read that is followed at once by a write is dropped and never reaches the bus.
- R8: `oe_n`=1 forces `rdata_oe` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the drive of a pending read.
- R9: `sleep`=1 forces `rdata_oe` to 0 at once. Reads and writes sampled while sleep is high are ignored, and the stored words survive the sleep.
- R10: Whenever `rdata_oe` is 0, `rdata` is 0.
- R11: A read returns the word stored by the most recent write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline state |
| pipe_mode | input | 1 | Output timing strap: 0 flow-through, 1 pipelined |
| ce | input | 1 | Chip enable, sampled on the clock edge |
| we | input | 1 | Write indication (1 write, 0 read), sampled with ce |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep request |
| rdata | output | DW | Data bus value (0 when not driven) |
| rdata_oe | output | 1 | Data bus drive-enable |

## Verification
The hardest case to reach is a pipelined read whose word is already held inside the block and is then dropped, because a write arrives on the very next edge. The bench produces it by issuing a read and then a write to a neighbouring address on back-to-back cycles, and it checks that the bus stays quiet for both of the following cycles. The asynchronous controls are the other hard case. The bench changes `oe_n` and `sleep` between clock edges while a read word is on the bus. It samples the outputs before the next edge, so the release is seen without any clock involved.

// File: rtl/srp_pkg.sv
package srp_pkg;

    // Output timing selected by the strap input
    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } srp_mode_e;

    // Qualified command seen at a clock edge
    typedef struct packed {
        logic rd;
        logic wr;
    } srp_op_t;

endpackage

// File: rtl/srp_cmd_decode.sv
module srp_cmd_decode
    import srp_pkg::*;
(
    input  logic    ce,
    input  logic    we,
    input  logic    sleep,
    output srp_op_t op
);

    // Sleep blocks every access; the array contents are left untouched
    always_comb begin
        op    = '0;
        op.rd = ce && !we && !sleep;
        op.wr = ce &&  we && !sleep;
    end

endmodule

// File: rtl/srp_array.sv
module srp_array #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/srp_out_pipe.sv
module srp_out_pipe
    import srp_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  srp_op_t       op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] arr_word,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] dout,
    output logic          drive
);

    typedef struct packed {
        logic          s1_vld;
        logic [AW-1:0] s1_addr;
        logic          s2_vld;
        logic [DW-1:0] s2_data;
    } pipe_t;

    pipe_t     st_d, st_q;
    srp_mode_e mode_sel;
    logic      vld_sel;
    logic [DW-1:0] word_sel;

    assign mode_sel = srp_mode_e'(pipe_mode);

    // Next-state: stage 1 holds the registered read/deselect, stage 2 the output register
    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = op.rd;
        if (op.rd) begin
            st_d.s1_addr = addr;
        end
        // a write right behind a read drops the word headed for the bus
        st_d.s2_vld = st_q.s1_vld && !op.wr;
        if (st_q.s1_vld) begin
            st_d.s2_data = arr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.s1_addr;

    always_comb begin
        if (mode_sel == MODE_PIPE) begin
            vld_sel  = st_q.s2_vld;
            word_sel = st_q.s2_data;
        end else begin
            vld_sel  = st_q.s1_vld;
            word_sel = arr_word;
        end
        drive = vld_sel && !oe_n && !sleep;
        dout  = drive ? word_sel : '0;
    end

    // R5: pipelined deselect releases the bus after the second edge
    assert_pipe_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !op.rd) |=> ##1 !drive);

    // R6: flow-through deselect releases the bus after the first edge
    assert_flow_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !op.rd) |=> !drive);

    // R7: a write never leads to the bus being driven in the next cycle
    assert_wr_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op.wr |=> !drive);

endmodule

// File: rtl/srp_read_path.sv
module srp_read_path
    import srp_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          ce,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);

    srp_op_t       op;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] arr_word;

    srp_cmd_decode u_dec (
        .ce    (ce),
        .we    (we),
        .sleep (sleep),
        .op    (op)
    );

    srp_array #(.AW(AW), .DW(DW)) u_arr (
        .clk     (clk),
        .wr_en   (op.wr),
        .wr_addr (addr),
        .wr_data (wdata),
        .rd_addr (rd_addr),
        .rd_data (arr_word)
    );

    srp_out_pipe #(.AW(AW), .DW(DW)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .op        (op),
        .addr      (addr),
        .arr_word  (arr_word),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .rd_addr   (rd_addr),
        .dout      (rdata),
        .drive     (rdata_oe)
    );

    // R9: sleep keeps the bus released
    assert_sleep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_oe);

    // R10: an undriven bus carries zero
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

endmodule

// File: tb/srp_read_path_tb_top.sv
module srp_read_path_tb_top;

    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          ce = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    srp_read_path #(.AW(AW), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .ce        (ce),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    function automatic logic [DW-1:0] pat(int a, int m);
        return DW'((a * 32'h0911) ^ ((m != 0) ? 32'hA5C3 : 32'h3C5A));
    endfunction

    // apply a command at the falling edge, return just after the next rising edge
    task automatic cyc(input logic c, input logic w, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        ce = c; we = w; addr = AW'(a); wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp_oe, input logic [DW-1:0] exp_d);
        n_chk++;
        if (rdata_oe !== exp_oe || rdata !== exp_d) begin
            n_fail++;
            $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                     req, rdata_oe, rdata, exp_oe, exp_d);
        end
    endtask

    // issue a read and return once its word is on the bus
    task automatic read_visible(input int a, input int m);
        cyc(1'b1, 1'b0, a, '0);
        if (m != 0) cyc(1'b0, 1'b0, 0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: oe=%b data=%h expected oe=0 data=0", rdata_oe, rdata);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            rst_n = 1'b0; pipe_mode = (m != 0); ce = 0; we = 0; oe_n = 0; sleep = 0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            rst_n = 1'b1;
            @(posedge clk); #1;
            chk("R1 reset", 1'b0, '0);

            // fill the array; writes must never drive (R7)
            for (int a = 0; a < 16; a++) begin
                cyc(1'b1, 1'b1, a, pat(a, m));
                chk("R7 write", 1'b0, '0);
            end

            // single reads: latency and deselect release
            for (int a = 0; a < 16; a++) begin
                cyc(1'b1, 1'b0, a, '0);
                if (m == 0) chk("R2 R11 flow read", 1'b1, pat(a, m));
                else        chk("R3 pipe first edge", 1'b0, '0);
                cyc(1'b0, 1'b0, 0, '0);
                if (m == 0) chk("R6 flow deselect", 1'b0, '0);
                else        chk("R3 R5 pipe data held", 1'b1, pat(a, m));
                if (m != 0) begin
                    cyc(1'b0, 1'b0, 0, '0);
                    chk("R5 pipe release", 1'b0, '0);
                end
            end

            // four-beat bursts
            for (int b = 0; b < 16; b += 4) begin
                for (int j = 0; j < 6; j++) begin
                    int idx;
                    if (j < 4) cyc(1'b1, 1'b0, b + j, '0);
                    else       cyc(1'b0, 1'b0, 0, '0);
                    idx = j - m;
                    if (idx >= 0 && idx < 4) chk("R4 burst", 1'b1, pat(b + idx, m));
                    else                     chk("R4 burst idle", 1'b0, '0);
                end
            end

            // read followed at once by a write: nothing reaches the bus
            cyc(1'b1, 1'b0, 5, '0);
            cyc(1'b1, 1'b1, 6, pat(6, m));
            chk("R7 dropped read", 1'b0, '0);
            cyc(1'b0, 1'b0, 0, '0);
            chk("R7 dropped read next", 1'b0, '0);

            // write then read the same address
            cyc(1'b1, 1'b1, 2, 16'hBEEF ^ DW'(m));
            read_visible(2, m);
            chk("R11 read after write", 1'b1, 16'hBEEF ^ DW'(m));
            cyc(1'b0, 1'b0, 0, '0);

            // asynchronous output enable
            read_visible(9, m);
            oe_n = 1'b1; #1;
            chk("R8 R10 oe off", 1'b0, '0);
            oe_n = 1'b0; #1;
            chk("R8 oe back", 1'b1, pat(9, m));
            cyc(1'b0, 1'b0, 0, '0);
            if (m != 0) cyc(1'b0, 1'b0, 0, '0);

            // sleep: immediate release, commands ignored, contents kept
            read_visible(10, m);
            sleep = 1'b1; #1;
            chk("R9 sleep off", 1'b0, '0);
            cyc(1'b1, 1'b1, 10, ~pat(10, m));
            chk("R9 sleep write", 1'b0, '0);
            cyc(1'b1, 1'b0, 10, '0);
            chk("R9 sleep read", 1'b0, '0);
            cyc(1'b0, 1'b0, 0, '0);
            chk("R9 sleep idle", 1'b0, '0);
            #1 sleep = 1'b0;
            read_visible(10, m);
            chk("R9 retained", 1'b1, pat(10, m));
            cyc(1'b0, 1'b0, 0, '0);
            if (m != 0) cyc(1'b0, 1'b0, 0, '0);
            chk("R10 final idle", 1'b0, '0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule